// File: doc/BRIEF.md
# Reset and Instruction Fetch Sequencer

This block is the fetch half of a small processor control unit. While the active-low reset is low it keeps every output quiet and forces its program counter, memory address and instruction holding register to known values. After reset is released it fetches the first instruction on its own, from a fixed reset vector, without doing any address arithmetic. After that first fetch it waits until a decoder asks for the next instruction.

Each fetch runs through five timed phases in a fixed order:

1. The next address is formed in the program counter.
2. That address is placed on the memory address bus.
3. The address is held for one full cycle so that it settles.
4. The memory output is enabled.
5. The returned word is captured.

A single-cycle valid strobe then tells the decoder that the word is ready. The next address is built from two pieces that are combined with a bitwise OR. One piece is the current address plus a step that was armed at the end of the previous fetch. The other piece is a branch offset supplied from outside.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low, `imem_rd` and `instr_valid` are 0, `imem_addr` equals `RESET_VEC` and `instr_word` is 0. Reset takes effect without waiting for a clock edge.
- R2: The first fetch after reset is released reads address `RESET_VEC` and ignores `branch_off`. `instr_valid` is high in the 5th cycle after the first rising edge at which `rst_n` is high.
- R3: Every later fetch reads the address `((previous fetch address + 1) | branch_off)`, taken modulo 2^`AW`. `branch_off` is sampled on the edge that follows acceptance of `next_fetch`.
- R4: `imem_addr` is stable in every cycle in which `imem_rd` is high. `imem_rd` never rises in a cycle in which `imem_addr` has just changed.
- R5: `instr_word` holds the `imem_data` value present during the last read cycle of the fetch. `instr_valid` is high for exactly one cycle per fetch, and never together with `imem_rd`.
- R6: In the idle state without `next_fetch`, `imem_rd` and `instr_valid` stay 0, and `imem_addr` and `instr_word` do not change.
- R7: When `next_fetch` is sampled high in the idle state, `instr_valid` is high in the 6th cycle after that edge.
- R8: A reset asserted in the middle of a fetch abandons that fetch. After release, fetching restarts from `RESET_VEC`.
- R9: `imem_rd` is high for exactly two consecutive cycles per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| next_fetch | input | 1 | Request for the next fetch; accepted only while idle |
| branch_off | input | AW | Address piece ORed into the next address |
| imem_addr | output | AW | Program memory address bus |
| imem_rd | output | 1 | Program memory output enable |
| imem_data | input | DW | Instruction word returned by program memory |
| instr_word | output | DW | Instruction holding register |
| instr_valid | output | 1 | Single-cycle strobe: `instr_word` is new |

## Verification
The bench aims at the corner cases of this block, and each one shows a distinct failure when the design is wrong:

- **First fetch after reset, with all ones on `branch_off`.** A sequencer that applied the OR to the first fetch would read the wrong address.
- **Offsets whose bits overlap the incremented address.** Offsets that set bits the increment would reach, and an offset that drives the address to all ones so the next step wraps to zero, expose adding in place of ORing, and a missing or doubled increment.
- **Read strobe against the address timing.** The bench counts read-enable cycles and compares them with the cycle in which the address changed. An enable that comes too early, or a read window of the wrong length, shows up there.
- **Idle stretches and mid-fetch reset.** Long idle periods catch a machine that runs on by itself. A reset asserted during a fetch catches a machine that resumes the abandoned fetch instead of restarting from the vector.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW = 13,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_VEC = '0,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          next_fetch,
  input  logic [AW-1:0] branch_off,
  output logic [AW-1:0] imem_addr,
  output logic          imem_rd,
  input  logic [DW-1:0] imem_data,
  output logic [DW-1:0] instr_word,
  output logic          instr_valid
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  typedef enum logic [2:0] {
    S_IDLE, S_CALC, S_DRIVE, S_SETTLE, S_READ, S_LATCH, S_DONE
  } phase_t;

  phase_t          phase;
  logic [AW-1:0]   pc;
  logic [AW-1:0]   step;
  logic            first;

  wire [AW-1:0] pc_next = (pc + step) | branch_off;

  assign imem_rd     = (phase == S_READ) || (phase == S_LATCH);
  assign instr_valid = (phase == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= S_CALC;
      pc         <= RESET_VEC;
      step       <= '0;
      first      <= 1'b1;
      imem_addr  <= RESET_VEC;
      instr_word <= '0;
    end else begin
      unique case (phase)
        S_IDLE:   if (next_fetch) phase <= S_CALC;
        S_CALC: begin
          pc    <= first ? RESET_VEC : pc_next;
          first <= 1'b0;
          phase <= S_DRIVE;
        end
        S_DRIVE: begin
          imem_addr <= pc;
          phase     <= S_SETTLE;
        end
        S_SETTLE: phase <= S_READ;
        S_READ:   phase <= S_LATCH;
        S_LATCH: begin
          instr_word <= imem_data;
          step       <= STEP_V;
          phase      <= S_DONE;
        end
        S_DONE:   phase <= S_IDLE;
        default:  phase <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] imem_addr,
  input logic          imem_rd,
  input logic          instr_valid
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!imem_rd && !instr_valid));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |-> $stable(imem_addr));

  // R4
  settle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imem_rd) |-> $stable(imem_addr));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);

  // R5
  valid_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !imem_rd);

  // R9
  rd_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imem_rd) |=> imem_rd);

  // R9
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rd && $past(imem_rd)) |=> !imem_rd);

endmodule

bind fetch_seq fetch_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
  .imem_rd(imem_rd), .instr_valid(instr_valid)
);

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam logic [AW-1:0] RV = 13'h0A40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          next_fetch = 1'b0;
  logic [AW-1:0] branch_off = '0;
  logic [AW-1:0] imem_addr;
  logic          imem_rd;
  logic [DW-1:0] imem_data;
  logic [DW-1:0] instr_word;
  logic          instr_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {3'b110, a};
  endfunction

  assign imem_data = imem_rd ? mem_word(imem_addr) : 16'hDEAD;

  fetch_seq #(.AW(AW), .DW(DW), .RESET_VEC(RV)) uut (
    .clk(clk), .rst_n(rst_n), .next_fetch(next_fetch), .branch_off(branch_off),
    .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_data(imem_data),
    .instr_word(instr_word), .instr_valid(instr_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one fetch; returns cycles to valid, read cycles and last read address.
  task automatic run_fetch(input bit req, input logic [AW-1:0] b,
                           output int cyc, output int rdc, output logic [AW-1:0] ra);
    cyc = 0; rdc = 0; ra = '0;
    if (req) begin
      next_fetch = 1'b1;
      branch_off = b;
    end
    while (!instr_valid && cyc < 20) begin
      @(negedge clk);
      next_fetch = 1'b0;
      cyc++;
      if (imem_rd) begin rdc++; ra = imem_addr; end
    end
  endtask

  task automatic check_fetch(input string tag, input bit req, input logic [AW-1:0] b,
                             input logic [AW-1:0] exp_a, input int exp_cyc);
    int cyc, rdc;
    logic [AW-1:0] ra;
    run_fetch(req, b, cyc, rdc, ra);
    chk({tag, " R7/R2 cycles to valid"}, cyc, exp_cyc);
    chk({tag, " R9 read cycles"}, rdc, 2);
    chk({tag, " R3 fetch address"}, ra, exp_a);
    chk({tag, " R5 instr_word"}, instr_word, mem_word(exp_a));
    @(negedge clk);
    chk({tag, " R5 valid one cycle"}, instr_valid, 0);
  endtask

  task automatic t_reset;
    branch_off = 13'h1FFF;
    repeat (3) @(negedge clk);
    chk("R1 rd in reset", imem_rd, 0);
    chk("R1 valid in reset", instr_valid, 0);
    chk("R1 addr in reset", imem_addr, RV);
    chk("R1 word in reset", instr_word, 0);
  endtask

  task automatic t_first;
    rst_n = 1'b1;
    check_fetch("first R2", 1'b0, '0, RV, 5);
  endtask

  task automatic t_sequence;
    check_fetch("seq plain", 1'b1, 13'h0000, RV + 13'd1, 6);
    check_fetch("seq or", 1'b1, 13'h0004, 13'h0A46, 6);
    check_fetch("seq high", 1'b1, 13'h1000, 13'h1A47, 6);
    check_fetch("seq overlap", 1'b1, 13'h0008, 13'h1A48, 6);
    check_fetch("seq ones", 1'b1, 13'h1FFF, 13'h1FFF, 6);
    check_fetch("seq wrap", 1'b1, 13'h0000, 13'h0000, 6);
  endtask

  task automatic t_idle;
    logic [AW-1:0] a0;
    logic [DW-1:0] w0;
    int rdseen = 0, vseen = 0;
    a0 = imem_addr; w0 = instr_word;
    branch_off = 13'h0155;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (imem_rd) rdseen++;
      if (instr_valid) vseen++;
    end
    chk("R6 no read while idle", rdseen, 0);
    chk("R6 no valid while idle", vseen, 0);
    chk("R6 addr held", imem_addr, a0);
    chk("R6 word held", instr_word, w0);
  endtask

  task automatic t_mid_reset;
    next_fetch = 1'b1;
    branch_off = 13'h0020;
    @(negedge clk);
    next_fetch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 rd dropped by reset", imem_rd, 0);
    chk("R8 addr to vector", imem_addr, RV);
    @(negedge clk);
    rst_n = 1'b1;
    branch_off = 13'h0101;
    check_fetch("restart R8", 1'b0, '0, RV, 5);
    check_fetch("after restart R3", 1'b1, 13'h0000, RV + 13'd1, 6);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_first();
    t_sequence();
    t_idle();
    t_mid_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end
endmodule